// File: doc/BRIEF.md
# Multi-Width Atomic Fetch-Add Register File

This block holds a byte-addressed store of counters that clients update atomically at 8, 16, 32 or 64 bit granularity. Every request names a byte address and an operand size in a 36-bit command word. Two kinds of request share one port. A load-style request carries a small signed increment inside the command word. It adds that increment and returns the value the register held beforehand. A store-style request takes its operand from a separate data word, and one command bit chooses whether that operand is added to the register or written over it.

Each accepted request is read, modified and written back in the cycle it is presented. Exactly one response follows on the next cycle. Because the update lands in the same cycle, a request that follows immediately sees the result of the one before it, even when their bytes overlap. Multi-byte registers sit little-endian in the byte array. A misaligned or out-of-range address is refused with an error response and leaves storage untouched. For a load-style request, command bit 13 marks a wait on a tag switch. This block has no tag-switch logic, so it answers such a request at once with the error flag clear.

Top module: `atomic_fetch_add_rf`

## Requirements
- R1: While reset is held and in the cycle after it, `rsp_valid` is 0. Reset clears every storage byte to zero.
- R2: Every cycle with `req_valid`=1 produces `rsp_valid`=1 on the following cycle, and only then. For an accepted request, `rsp_data` is the pre-update register value sign-extended to 64 bits.
- R3: On a load-style request (`req_store`=0), command bits 35:14 are a signed 22-bit increment. It is sign-extended to the operand width and added, and the sum wraps modulo 2^width.
- R4: On a store-style request with command bit 13 = 0, the low `width` bits of `req_wdata` are added to the register, wrapping modulo 2^width.
- R5: On a store-style request with command bit 13 = 1, the low `width` bits of `req_wdata` replace the register.
- R6: Command bits 12:11 select the size: 0 = 8, 1 = 16, 2 = 32 and 3 = 64 bits. The address in bits 10:0 names the least significant byte, and the register is stored little-endian. Bytes outside the addressed register are never altered.
- R7: Some requests are misaligned: a 16-bit address that is not a multiple of 2, a 32-bit address that is not a multiple of 4, or a 64-bit address that is not a multiple of 8. Such a request answers `rsp_err`=1 with `rsp_data`=0 and changes no storage.
- R8: An address at or above 2^`ADDR_W` answers `rsp_err`=1 with `rsp_data`=0 and changes no storage.
- R9: On a load-style request, command bit 13 (tag-wait) has no effect. The response comes on the next cycle with `rsp_err`=0 and the same result as with the bit clear.
- R10: Back-to-back requests to the same or overlapping bytes are serialized: the second request returns and builds on the result of the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present this cycle |
| req_store | input | 1 | 1 = store-style request, 0 = load-style request |
| req_cmd | input | 36 | Command: [35:14] increment, [13] mode/tag-wait, [12:11] size, [10:0] byte address |
| req_wdata | input | 64 | Store-style operand |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_err | output | 1 | Request refused (misaligned or out of range) |
| rsp_data | output | 64 | Pre-update value, sign-extended; 0 on error |

## Verification
The bench builds the block with `ADDR_W` = 6, which gives a 64-byte store. This puts the out-of-range refusal within reach of the 11-bit address field, for example at address 64 and at 2047. It also lets a run of a few hundred random operations at all four sizes land on overlapping registers many times over. The small store makes wraparound at every width, sign extension of returned values, and little-endian byte placement visible with a handful of directed accesses. A behavioural byte-array model checks every cycle, idle ones included.

// File: rtl/atomic_fetch_add_rf.sv
module atomic_fetch_add_rf #(
  parameter int ADDR_W = 11
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic        req_store,
  input  logic [35:0] req_cmd,
  input  logic [63:0] req_wdata,
  output logic        rsp_valid,
  output logic        rsp_err,
  output logic [63:0] rsp_data
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int LANES = 8;
  localparam int INC_W = 22;

  logic [7:0] mem [DEPTH];

  logic [10:0]       ra;
  logic [1:0]        sz;
  logic [ADDR_W-1:0] base;
  logic              misal, oob, do_wr, ovw;
  logic [LANES-1:0]  lane_en;
  logic [ADDR_W-1:0] lidx [LANES];
  logic [63:0]       old_raw, old_sext, operand, sum, newv;

  assign ra    = req_cmd[10:0];
  assign sz    = req_cmd[12:11];
  assign base  = ra[ADDR_W-1:0];
  assign ovw   = req_store & req_cmd[13];
  assign misal = (sz == 2'd1 && ra[0]) || (sz == 2'd2 && |ra[1:0]) || (sz == 2'd3 && |ra[2:0]);
  assign oob   = (ra >> ADDR_W) != 11'd0;
  assign do_wr = req_valid & ~misal & ~oob;

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign lane_en[k]        = k < (1 << sz);
    assign lidx[k]           = base + ADDR_W'(k);
    assign old_raw[8*k +: 8] = lane_en[k] ? mem[lidx[k]] : 8'h00;
  end

  always_comb begin
    case (sz)
      2'd0:    old_sext = {{56{old_raw[7]}},  old_raw[7:0]};
      2'd1:    old_sext = {{48{old_raw[15]}}, old_raw[15:0]};
      2'd2:    old_sext = {{32{old_raw[31]}}, old_raw[31:0]};
      default: old_sext = old_raw;
    endcase
  end

  assign operand = req_store ? req_wdata : {{(64-INC_W){req_cmd[35]}}, req_cmd[35:14]};
  assign sum     = old_raw + operand;
  assign newv    = ovw ? operand : sum;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_data  <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid & (misal | oob);
      rsp_data  <= do_wr ? old_sext : 64'd0;
      for (int k = 0; k < LANES; k++)
        if (do_wr && lane_en[k]) mem[lidx[k]] <= newv[8*k +: 8];
    end
  end
endmodule

module afr_chk #(
  parameter int ADDR_W = 11
) (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_store,
  input logic [35:0] req_cmd,
  input logic [63:0] req_wdata,
  input logic        rsp_valid,
  input logic        rsp_err,
  input logic [63:0] rsp_data
);
  logic       bad_align, bad_range;
  logic [1:0] s;
  assign s         = req_cmd[12:11];
  assign bad_align = (s == 2'd1) ? req_cmd[0] :
                     (s == 2'd2) ? (req_cmd[1:0] != 2'b00) :
                     (s == 2'd3) ? (req_cmd[2:0] != 3'b000) : 1'b0;
  assign bad_range = req_cmd[10:0] >= 11'(1 << ADDR_W) && ADDR_W < 11;

  // R1
  reset_quiet_chk: assert property (@(posedge clk) rst |=> !rsp_valid);

  // R2
  rsp_follows_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  // R2
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  // R7
  misalign_err_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && bad_align) |=> (rsp_err && rsp_data == 64'd0));

  // R8
  range_err_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && bad_range) |=> (rsp_err && rsp_data == 64'd0));

  // R9
  tagwait_ok_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_store && req_cmd[13] && !bad_align && !bad_range) |=> !rsp_err);

  // R7
  err_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> rsp_valid);
endmodule

bind atomic_fetch_add_rf afr_chk #(.ADDR_W(ADDR_W)) u_afr_chk (.*);

// File: tb/test_atomic_fetch_add_rf.sv
module test_atomic_fetch_add_rf;
  localparam int AW = 6;
  localparam int DEP = 1 << AW;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_store = 1'b0;
  logic [35:0] req_cmd = '0;
  logic [63:0] req_wdata = '0;
  logic        rsp_valid, rsp_err;
  logic [63:0] rsp_data;

  int checks = 0;
  int fails = 0;
  logic [7:0] m [DEP];

  always #5 clk = ~clk;

  atomic_fetch_add_rf #(.ADDR_W(AW)) i_atomic_fetch_add_rf (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_store(req_store),
    .req_cmd(req_cmd), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_data(rsp_data));

  function automatic logic [35:0] mk(int a, int sz, bit b13, logic [21:0] inc);
    return {inc, b13, 2'(sz), 11'(a)};
  endfunction

  task automatic chk(string tag, logic [65:0] act, logic [65:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual v/e/data=%h expected %h", tag, act, exp);
    end
  endtask

  task automatic model(input bit st, input logic [35:0] cmd, input logic [63:0] wd,
                       output bit err, output logic [63:0] dat);
    int a, n;
    logic [63:0] old, opnd, nv, msk;
    a = int'(cmd[10:0]);
    n = 1 << cmd[12:11];
    if ((a % n) != 0 || a >= DEP) begin err = 1; dat = 0; return; end
    err = 0;
    old = 0;
    for (int i = 0; i < n; i++) old |= 64'(m[a+i]) << (8*i);
    opnd = st ? wd : {{42{cmd[35]}}, cmd[35:14]};
    nv = (st && cmd[13]) ? opnd : old + opnd;
    for (int i = 0; i < n; i++) m[a+i] = nv[8*i +: 8];
    if (n == 8) dat = old;
    else begin
      msk = (64'h1 << (8*n)) - 1;
      dat = old[8*n-1] ? (old | ~msk) : old;
    end
  endtask

  // drive at a negedge, compare the registered response at the next negedge
  task automatic issue(string tag, bit st, logic [35:0] cmd, logic [63:0] wd);
    bit e;
    logic [63:0] d;
    req_valid = 1'b1; req_store = st; req_cmd = cmd; req_wdata = wd;
    model(st, cmd, wd, e, d);
    @(negedge clk);
    chk(tag, {rsp_valid, rsp_err, rsp_data}, {1'b1, e, d});
  endtask

  task automatic idle(string tag);
    req_valid = 1'b0;
    @(negedge clk);
    chk(tag, {rsp_valid, 65'd0}, 66'd0);
  endtask

  initial begin
    #(200000 * 10);
    fails++; checks++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEP; i++) m[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 reset", {rsp_valid, 65'd0}, 66'd0);
    rst = 1'b0;
    idle("R1 after reset");
    issue("R1 zero contents", 0, mk(40, 3, 0, 22'd0), 0);

    // R5 overwrite then R6 little-endian byte reads
    issue("R5 write64", 1, mk(8, 3, 1, 0), 64'h8877665544332211);
    issue("R6 byte0", 0, mk(8, 0, 0, 0), 0);
    issue("R6 byte7 sext", 0, mk(15, 0, 0, 0), 0);
    issue("R6 half", 0, mk(10, 1, 0, 0), 0);
    issue("R6 word hi", 0, mk(12, 2, 0, 0), 0);
    issue("R6 whole", 0, mk(8, 3, 0, 0), 0);

    // R3 negative increment and wrap at 32 bits
    issue("R3 add -1 w32", 0, mk(16, 2, 0, 22'h3FFFFF), 0);
    issue("R3 add +1 wrap w32", 0, mk(16, 2, 0, 22'd1), 0);
    issue("R3 neighbour untouched", 0, mk(20, 2, 0, 0), 0);
    issue("R3 max inc w64", 0, mk(24, 3, 0, 22'h1FFFFF), 0);
    issue("R3 min inc w64", 0, mk(24, 3, 0, 22'h200000), 0);
    issue("R3 read w64", 0, mk(24, 3, 0, 0), 0);

    // R4 store add only low width bits
    issue("R4 add16", 1, mk(2, 1, 0, 0), 64'h12345_FFFF);
    issue("R4 add16 again", 1, mk(2, 1, 0, 0), 64'h0000_0003);
    issue("R4 read", 0, mk(0, 3, 0, 0), 0);
    issue("R5 byte 7F", 1, mk(33, 0, 1, 0), 64'h7F);
    issue("R4 byte wrap to 80", 1, mk(33, 0, 0, 0), 64'h1);
    issue("R4 byte read", 0, mk(33, 0, 0, 0), 0);

    // R7 misaligned
    issue("R7 half odd", 1, mk(1, 1, 1, 0), 64'hFFFF);
    issue("R7 word at 6", 0, mk(6, 2, 0, 22'd5), 0);
    issue("R7 dword at 4", 1, mk(4, 3, 0, 0), 64'h1);
    issue("R7 unchanged", 0, mk(0, 3, 0, 0), 0);
    // R8 out of range
    issue("R8 addr 64", 1, mk(64, 0, 1, 0), 64'h5A);
    issue("R8 addr 2047", 0, mk(2047, 0, 0, 22'd1), 0);
    issue("R8 addr 1024 w64", 0, mk(1024, 3, 0, 22'd1), 0);
    issue("R8 unchanged", 0, mk(0, 0, 0, 0), 0);
    idle("R2 idle gap");
    // R9 tag-wait flag
    issue("R9 tagwait load", 0, mk(48, 1, 1, 22'd7), 0);
    issue("R9 tagwait load again", 0, mk(48, 1, 1, 22'h3FFFF0), 0);
    // R10 back-to-back overlapping
    issue("R10 b2b word", 0, mk(56, 2, 0, 22'd100), 0);
    issue("R10 b2b byte inside", 1, mk(57, 0, 0, 0), 64'h01);
    issue("R10 b2b dword over", 0, mk(56, 3, 0, 22'd1), 0);
    issue("R10 b2b same", 0, mk(56, 3, 0, 22'd1), 0);
    idle("R2 idle");

    for (int t = 0; t < 400; t++) begin
      int sz, a;
      bit st, b13;
      sz = int'($urandom_range(0, 3));
      a = int'($urandom_range(0, DEP - 1)) & ~((1 << sz) - 1);
      if (($urandom % 16) == 0) a = int'($urandom_range(0, 2047));
      st = 1'($urandom);
      b13 = 1'($urandom);
      if (($urandom % 8) == 0) idle("R2 random idle");
      else issue("R10 random", st, mk(a, sz, b13, 22'($urandom)), {$urandom, $urandom});
    end
    idle("R2 final");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule